// File: doc/BRIEF.md
# Synchronous SRAM Write And Output Path

This block puts a synchronous single-port SRAM interface around a small on-chip array. Every control, the address and the write data are captured on the rising clock edge. Writes can go to any subset of the byte lanes, or to all lanes at once through a global write strobe. A read can be returned straight from the array (flow-through) or through one extra output register (pipelined). A static mode pin selects between the two. The output enable and the sleep input act asynchronously on the output drive indication.

In pipelined mode, a cycle that is not a read removes the drive one register stage earlier than a read adds it. A deselect or a write stops the output right after the edge that captures it, while read data only shows up after the following edge. Sleep blocks writes and keeps the drive off. The array contents stay as they are.

Top module: `ssram_port`

## Requirements
- R1: With `gwe_i` low, `ce_i` high and `bwe_i` high, a rising edge writes only the byte lanes whose bit in `lane_sel_i` is 1. Lane k is data bits [9k+8:9k]. The other lanes of that word keep their contents.
- R2: A selected cycle with `bwe_i` high, `lane_sel_i` all zero and `gwe_i` low writes nothing and counts as a read.
- R3: A selected cycle with `gwe_i` high writes all four lanes, whatever `bwe_i` and `lane_sel_i` are.
- R4: Flow-through (`pipe_mode_i` = 0). A read captured at edge n drives `drive_o` high and shows the word on `rdata_o` from edge n until edge n+1.
- R5: Pipelined (`pipe_mode_i` = 1). The word read at edge n appears on `rdata_o` after edge n+1. `drive_o` is high after edge n+1 only if the cycles captured at edges n and n+1 were both reads.
- R6: Pipelined. A deselect (`ce_i` low) or a write captured at edge n holds `drive_o` low from edge n until edge n+1.
- R7: `drive_o` is low whenever `oe_i` is low, with no clock needed.
- R8: While `sleep_i` is high, `drive_o` is low with no clock needed. A cycle captured with `sleep_i` high writes nothing and counts as a deselect. The array keeps its contents.
- R9: A write captured at edge n holds `drive_o` low from edge n until edge n+1, in both modes.
- R10: A read captured one edge after a write to the same address returns the newly written data.
- R11: While `rst_ni` is low, and after reset until the first read is captured, `drive_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset of the control pipeline |
| addr_i | input | 8 | Word address |
| ce_i | input | 1 | Chip enable, active high |
| bwe_i | input | 1 | Byte-write enable |
| lane_sel_i | input | 4 | Per-lane write selects |
| gwe_i | input | 1 | Global write, all lanes |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| pipe_mode_i | input | 1 | 0 flow-through, 1 pipelined (static) |
| oe_i | input | 1 | Asynchronous output enable |
| sleep_i | input | 1 | Asynchronous sleep |
| rdata_o | output | 36 | Read data |
| drive_o | output | 1 | Read data valid and driven |

## Verification
The assertions assume that `pipe_mode_i` only changes while the pipeline holds no reads. They also assume that every other control is stable around the rising edge, so the edge sees one clear command. The bench changes the mode only after two deselect cycles. It drives all inputs at the falling edge, and it raises or lowers `oe_i` and `sleep_i` away from the rising edge. All 256 words are written before any read, so no read ever returns uninitialised array contents.

// File: rtl/ssram_pkg.sv
package ssram_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_e;
endpackage

// File: rtl/ssram_cmd_decode.sv
module ssram_cmd_decode
  import ssram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             ce_i,
  input  logic             sleep_i,
  input  logic             bwe_i,
  input  logic [LANES-1:0] lane_sel_i,
  input  logic             gwe_i,
  output cyc_kind_e        kind_o,
  output logic [LANES-1:0] lane_we_o
);
  always_comb begin
    kind_o    = CYC_IDLE;
    lane_we_o = '0;
    if (ce_i && !sleep_i) begin
      if (gwe_i) begin
        // global write wins over lane controls
        kind_o    = CYC_WRITE;
        lane_we_o = '1;
      end else if (bwe_i && (|lane_sel_i)) begin
        kind_o    = CYC_WRITE;
        lane_we_o = lane_sel_i;
      end else begin
        kind_o = CYC_READ;
      end
    end
  end
endmodule

// File: rtl/ssram_array.sv
module ssram_array #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic [LANES-1:0] we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [DW-1:0]    rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i[l]) mem_q[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem_q[raddr_i];
  end
endmodule

// File: rtl/ssram_out_stage.sv
module ssram_out_stage #(
  parameter int DW = 36
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pipe_mode_i,
  input  logic          rd_s1_i,
  input  logic [DW-1:0] arr_data_i,
  input  logic          oe_i,
  input  logic          sleep_i,
  output logic [DW-1:0] rdata_o,
  output logic          drive_o
);
  logic          rd_s2_q;
  logic [DW-1:0] data_s2_q;
  logic          live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_s2_q   <= 1'b0;
      data_s2_q <= '0;
    end else begin
      rd_s2_q   <= rd_s1_i;
      data_s2_q <= arr_data_i;
    end
  end

  always_comb begin
    if (pipe_mode_i) begin
      rdata_o = data_s2_q;
      // stage-1 non-read cuts drive one stage ahead of read data
      live    = rd_s1_i && rd_s2_q;
    end else begin
      rdata_o = arr_data_i;
      live    = rd_s1_i;
    end
  end

  assign drive_o = oe_i && !sleep_i && live;
endmodule

// File: rtl/ssram_port.sv
module ssram_port
  import ssram_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             ce_i,
  input  logic             bwe_i,
  input  logic [LANES-1:0] lane_sel_i,
  input  logic             gwe_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             pipe_mode_i,
  input  logic             oe_i,
  input  logic             sleep_i,
  output logic [DW-1:0]    rdata_o,
  output logic             drive_o
);
  cyc_kind_e        kind_d, kind_s1_q;
  logic [LANES-1:0] lane_we;
  logic [AW-1:0]    addr_s1_q;
  logic [DW-1:0]    arr_data;

  ssram_cmd_decode #(.LANES(LANES)) u_dec (
    .ce_i       (ce_i),
    .sleep_i    (sleep_i),
    .bwe_i      (bwe_i),
    .lane_sel_i (lane_sel_i),
    .gwe_i      (gwe_i),
    .kind_o     (kind_d),
    .lane_we_o  (lane_we)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_s1_q <= CYC_IDLE;
      addr_s1_q <= '0;
    end else begin
      kind_s1_q <= kind_d;
      addr_s1_q <= addr_i;
    end
  end

  ssram_array #(.LANES(LANES), .LANE_W(LANE_W), .DEPTH(DEPTH)) u_arr (
    .clk_i   (clk_i),
    .we_i    (lane_we),
    .waddr_i (addr_i),
    .wdata_i (wdata_i),
    .raddr_i (addr_s1_q),
    .rdata_o (arr_data)
  );

  ssram_out_stage #(.DW(DW)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pipe_mode_i (pipe_mode_i),
    .rd_s1_i     (kind_s1_q == CYC_READ),
    .arr_data_i  (arr_data),
    .oe_i        (oe_i),
    .sleep_i     (sleep_i),
    .rdata_o     (rdata_o),
    .drive_o     (drive_o)
  );
endmodule

// File: rtl/ssram_port_chk.sv
module ssram_port_chk #(
  parameter int LANES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_i,
  input logic             bwe_i,
  input logic [LANES-1:0] lane_sel_i,
  input logic             gwe_i,
  input logic             pipe_mode_i,
  input logic             oe_i,
  input logic             sleep_i,
  input logic             drive_o
);
  logic [1:0] warm_q;
  logic       wr_cyc, rd_cyc;

  assign wr_cyc = ce_i && !sleep_i && (gwe_i || (bwe_i && (|lane_sel_i)));
  assign rd_cyc = ce_i && !sleep_i && !wr_cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             warm_q <= 2'd0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R7
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> !drive_o);

  // R8
  sleep_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !drive_o);

  // R9
  wr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cyc |=> !drive_o);

  // R6
  pipe_desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipe_mode_i && !ce_i) |=> !drive_o);

  // R5
  pipe_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 2'd2 && pipe_mode_i && $past(pipe_mode_i) && oe_i && !sleep_i
     && $past(rd_cyc) && $past(rd_cyc, 2)) |-> drive_o);

  // R4
  flow_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 2'd1 && !pipe_mode_i && oe_i && !sleep_i && $past(rd_cyc)) |-> drive_o);
endmodule

bind ssram_port ssram_port_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/ssram_port_test.sv
module ssram_port_test;
  localparam int LANES = 4, LANE_W = 9, DEPTH = 256;
  localparam int AW = 8, DW = 36;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_ni = 1'b0;
  logic [AW-1:0]    addr = '0;
  logic             ce = 1'b0, bwe = 1'b0, gwe = 1'b0;
  logic [LANES-1:0] lsel = '0;
  logic [DW-1:0]    wdata = '0;
  logic             pipe = 1'b0, oe = 1'b1, sleep = 1'b0;
  logic [DW-1:0]    rdata;
  logic             drive;

  ssram_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .ce_i(ce), .bwe_i(bwe),
    .lane_sel_i(lsel), .gwe_i(gwe), .wdata_i(wdata), .pipe_mode_i(pipe),
    .oe_i(oe), .sleep_i(sleep), .rdata_o(rdata), .drive_o(drive)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [DW-1:0] ref_mem [DEPTH];
  logic          m_rd1 = 1'b0, m_rd2 = 1'b0;
  logic [AW-1:0] m_addr1 = '0;
  logic [DW-1:0] m_dat2 = '0;

  task automatic check_now(string tag);
    logic          exp_drv;
    logic [DW-1:0] exp_dat;
    #1;
    exp_drv = oe && !sleep && (pipe ? (m_rd1 && m_rd2) : m_rd1);
    exp_dat = pipe ? m_dat2 : ref_mem[m_addr1];
    checks++;
    if (drive !== exp_drv) begin
      errors++;
      $display("FAIL %s drive_o actual %0b expected %0b at %0t", tag, drive, exp_drv, $time);
    end
    if (exp_drv) begin
      checks++;
      if (rdata !== exp_dat) begin
        errors++;
        $display("FAIL %s rdata_o actual %h expected %h at %0t", tag, rdata, exp_dat, $time);
      end
    end
  endtask

  task automatic model_step();
    logic is_wr, is_rd;
    is_wr = ce && !sleep && (gwe || (bwe && (|lsel)));
    is_rd = ce && !sleep && !is_wr;
    m_dat2 = ref_mem[m_addr1];
    m_rd2  = m_rd1;
    if (is_wr)
      for (int l = 0; l < LANES; l++)
        if (gwe || lsel[l]) ref_mem[addr][l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
    m_rd1   = is_rd;
    m_addr1 = addr;
  endtask

  task automatic cyc(string tag, logic c, logic [AW-1:0] a, logic b, logic [LANES-1:0] ls,
                     logic g, logic [DW-1:0] d, logic o = 1'b1, logic s = 1'b0);
    ce = c; addr = a; bwe = b; lsel = ls; gwe = g; wdata = d; oe = o; sleep = s;
    check_now(tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic rd(string tag, logic [AW-1:0] a);
    cyc(tag, 1'b1, a, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic idle(string tag);
    cyc(tag, 1'b0, '0, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic rand_run(string tag, int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(tag, r[0] | r[1], {4'd0, r[7:4]}, r[8], r[12:9], r[13] & r[14],
          {$urandom, $urandom}, |r[17:15], r[20:18] == 3'd0);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e));
    repeat (3) @(negedge clk);
    check_now("R11");
    rst_ni = 1'b1;
    @(negedge clk);
    check_now("R11");

    // flow-through
    for (int a = 0; a < DEPTH; a++)
      cyc("R3", 1'b1, AW'(a), 1'b0, '0, 1'b1, {4{AW'(a), 1'b1}} ^ 36'h5a5a5a5a5);
    for (int a = 0; a < 8; a++) rd("R4", AW'(a));
    cyc("R3", 1'b1, 8'd2, 1'b1, 4'b0001, 1'b1, 36'h123456789);
    rd("R3", 8'd2);
    cyc("R1", 1'b1, 8'd3, 1'b1, 4'b0101, 1'b0, 36'hfedcba987);
    rd("R1", 8'd3);
    cyc("R1", 1'b1, 8'd3, 1'b1, 4'b1000, 1'b0, 36'h0aaaaaaaa);
    rd("R1", 8'd3);
    cyc("R2", 1'b1, 8'd4, 1'b1, 4'b0000, 1'b0, 36'hbbbbbbbbb);
    rd("R2", 8'd4);
    cyc("R10", 1'b1, 8'd5, 1'b0, '0, 1'b1, 36'h31415926a);
    rd("R10", 8'd5);
    rd("R9", 8'd6);
    cyc("R9", 1'b1, 8'd7, 1'b0, '0, 1'b1, 36'h777777777);
    rd("R9", 8'd7);
    rd("R7", 8'd8);
    cyc("R7", 1'b1, 8'd9, 1'b0, '0, 1'b0, '0, 1'b0);
    rd("R7", 8'd9);
    cyc("R8", 1'b1, 8'd10, 1'b0, '0, 1'b1, 36'hdeadbeef1, 1'b1, 1'b1);
    cyc("R8", 1'b1, 8'd10, 1'b0, '0, 1'b0, '0, 1'b1, 1'b1);
    rd("R8", 8'd10);
    rd("R8", 8'd10);
    rand_run("R4", 300);

    // pipelined
    idle("R6"); idle("R6");
    pipe = 1'b1;
    for (int a = 0; a < 4; a++) rd("R5", AW'(a));
    idle("R6");
    rd("R6", 8'd4);
    idle("R6");
    rd("R6", 8'd5);
    cyc("R6", 1'b1, 8'd5, 1'b0, '0, 1'b1, 36'h5a5a00ff1);
    rd("R10", 8'd5);
    rd("R10", 8'd5);
    rd("R5", 8'd6);
    cyc("R7", 1'b1, 8'd7, 1'b0, '0, 1'b0, '0, 1'b0);
    rd("R7", 8'd7);
    cyc("R8", 1'b1, 8'd8, 1'b0, '0, 1'b1, 36'hcafef00d2, 1'b1, 1'b1);
    rd("R8", 8'd8);
    rd("R8", 8'd8);
    rd("R8", 8'd8);
    rand_run("R5", 300);
    idle("R6");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule